// File: doc/BRIEF.md
# Coprocessor Response Primitive Sequencer

This block is the control core of a floating-point coprocessor's host-facing register port. The host starts an instruction by writing an instruction word into the command register. It then polls the response register until it is allowed to move on. The sequencer picks the primitive returned on each poll. It starts the operand transfer phase, hands the instruction to the single execution unit when that phase ends, and releases the host at that point, while the unit is still computing.

If the host issues a second instruction while the execution unit is still busy, the new instruction is parked untouched. No operand transfer is started for it. The host is held in a polling loop with a primitive that also lets it service pending interrupts between polls. When the busy instruction finishes normally, the parked instruction begins. If the busy instruction finishes with an exception, the parked instruction, or the next one written, gets a take-exception primitive carrying the unit's exception code.

Primitive layout (16 bits): bit 13 is the come-again flag CA, bits 12:9 hold a function code, bit 8 is the interrupts-allowed flag IA, and bits 3:0 hold an exception code. All other bits read as zero. The function code is 4'b0100 for a null primitive and 4'b1110 for take-exception.

Top module: `cp_resp_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, rsp_data reads 16'h0800 (null, CA=0, IA=0), and opnd_go and exe_start are low.
- R2: A command write with the unit idle and no pending exception raises opnd_go for exactly one cycle, visible the cycle after the write. Responses then read 16'h2800 (null, CA=1, IA=0) until the transfer phase ends.
- R3: An opnd_done pulse during the transfer phase raises exe_start for one cycle on the next cycle, with exe_cmd equal to the command word. Responses then read 16'h0800 (CA=0), releasing the host while the unit computes.
- R4: A command write while the unit is busy produces responses of 16'h2900 (null, CA=1, IA=1). opnd_go stays low for as long as the unit stays busy.
- R5: The 16'h2900 response is unchanged across repeated reads until exe_done. An exe_done without exception makes the parked command start: opnd_go rises two cycles after the exe_done cycle, and exe_cmd later carries that command.
- R6: An exe_done with exe_exc high while a command is parked produces a take-exception response 16'h1C00 | code, with CA=0 and the code in bits 3:0. The parked command never raises opnd_go.
- R7: An exception reported with no command parked is latched. The next command write then returns the take-exception response for that code and raises no opnd_go.
- R8: A command write after a take-exception response clears the code. If the unit is idle, that write starts normally, with a 16'h2800 response and one opnd_go pulse.
- R9: A command write and a response read in the same cycle return the primitive that applies after the write.
- R10: rsp_data changes only in the cycle after a cycle with rsp_rd high and holds its value otherwise.
- R11: A command write during the transfer phase or while parked is ignored. The response, the opnd_go count and the word later sent on exe_cmd are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_data | input | 16 | Instruction word written to the command register |
| rsp_rd | input | 1 | Response register read strobe |
| rsp_data | output | 16 | Response primitive, registered, valid the cycle after rsp_rd |
| opnd_go | output | 1 | One-cycle pulse that starts the operand transfer phase |
| opnd_done | input | 1 | Pulse marking the end of the operand transfer phase |
| exe_start | output | 1 | One-cycle pulse handing the instruction to the execution unit |
| exe_cmd | output | 16 | Instruction word for the execution unit, valid with exe_start |
| exe_done | input | 1 | Execution unit finished its instruction |
| exe_exc | input | 1 | Finished instruction ended in an exception (with exe_done) |
| exe_code | input | 4 | Exception code (with exe_done and exe_exc) |

## Verification
The sequencer state moves on the clock edge that samples a write, opnd_done or exe_done. opnd_go and exe_start appear one edge after their cause. A parked command needs one further edge after exe_done, because it waits for the busy flag to clear, so its opnd_go lands two cycles after exe_done. A response read is captured on the edge that samples rsp_rd, so the bench drives inputs on the falling edge and reads rsp_data on the next falling edge. A falling-edge monitor counts every opnd_go and exe_start pulse. The bench waits at least one spare cycle before comparing those counts, so a pulse is never missed or counted before it is due. The sweeps cover every 4-bit exception code on the parked path, and several command words, each with an ignored overwrite.

// File: rtl/cp_resp_pkg.sv
package cp_resp_pkg;

  // Sequencer states; the response primitive is a pure function of these
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,   // nothing in transfer, host released
    ST_XFER = 2'd1,   // operand transfer phase of the current command
    ST_WAIT = 2'd2,   // command parked behind a busy execution unit
    ST_EXC  = 2'd3    // take-exception primitive presented
  } seq_st_e;

  localparam int unsigned FN_W        = 4;
  localparam logic [FN_W-1:0] FN_NULL     = 4'b0100;
  localparam logic [FN_W-1:0] FN_TAKE_EXC = 4'b1110;

endpackage

// File: rtl/cp_resp_busy.sv
module cp_resp_busy #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,     // instruction handed to the unit
  input  logic              exe_done,
  input  logic              exe_exc,
  input  logic [CODE_W-1:0] exe_code,
  input  logic              consume,    // latched exception taken by a command
  output logic              busy,
  output logic              exc_pend,
  output logic [CODE_W-1:0] exc_code
);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
    end else if (launch) begin
      busy <= 1'b1;
    end else if (exe_done) begin
      busy <= 1'b0;
    end
  end

  // Single-entry exception latch: a new report wins over a same-cycle consume
  always_ff @(posedge clk) begin
    if (rst) begin
      exc_pend <= 1'b0;
      exc_code <= '0;
    end else if (exe_done && exe_exc) begin
      exc_pend <= 1'b1;
      exc_code <= exe_code;
    end else if (consume) begin
      exc_pend <= 1'b0;
    end
  end

  // R5: a completion always frees the unit on the next cycle
  p_busy_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (exe_done && !launch) |=> !busy);

endmodule

// File: rtl/cp_resp_ctl.sv
module cp_resp_ctl
  import cp_resp_pkg::*;
#(
  parameter int unsigned CMD_W  = 16,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              opnd_done,
  input  logic              busy,
  input  logic              exc_pend,
  input  logic [CODE_W-1:0] exc_code,
  output seq_st_e           st_nx,
  output logic [CODE_W-1:0] code_nx,
  output logic              consume,
  output logic              launch,
  output logic              opnd_go,
  output logic              exe_start,
  output logic [CMD_W-1:0]  exe_cmd
);

  seq_st_e           st_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [CODE_W-1:0] code_q;
  logic [CMD_W-1:0]  cmd_nx;

  always_comb begin
    st_nx   = st_q;
    cmd_nx  = cmd_q;
    code_nx = code_q;
    consume = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_EXC: begin
        if (cmd_wr) begin
          cmd_nx  = cmd_data;
          code_nx = '0;
          if (exc_pend) begin
            st_nx   = ST_EXC;
            code_nx = exc_code;
            consume = 1'b1;
          end else if (busy) begin
            st_nx = ST_WAIT;
          end else begin
            st_nx = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (opnd_done) st_nx = ST_IDLE;
      end
      ST_WAIT: begin
        if (!busy) begin
          if (exc_pend) begin
            st_nx   = ST_EXC;
            code_nx = exc_code;
            consume = 1'b1;
          end else begin
            st_nx = ST_XFER;
          end
        end
      end
      default: st_nx = ST_IDLE;
    endcase
  end

  assign launch = (st_q == ST_XFER) && opnd_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cmd_q     <= '0;
      code_q    <= '0;
      opnd_go   <= 1'b0;
      exe_start <= 1'b0;
      exe_cmd   <= '0;
    end else begin
      st_q      <= st_nx;
      cmd_q     <= cmd_nx;
      code_q    <= code_nx;
      opnd_go   <= (st_nx == ST_XFER) && (st_q != ST_XFER);
      exe_start <= launch;
      if (launch) exe_cmd <= cmd_q;
    end
  end

  // R2: the transfer start is a single-cycle pulse
  p_go_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    opnd_go |=> !opnd_go);

  // R6: an exception presentation never starts anything
  p_exc_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_EXC) |-> (!opnd_go && !exe_start));

endmodule

// File: rtl/cp_resp_enc.sv
module cp_resp_enc
  import cp_resp_pkg::*;
#(
  parameter int unsigned PRIM_W = 16,
  parameter int unsigned CA_BIT = 13,
  parameter int unsigned IA_BIT = 8,
  parameter int unsigned FN_LO  = 9,
  parameter int unsigned CODE_W = 4
) (
  input  seq_st_e           st,
  input  logic [CODE_W-1:0] code,
  output logic [PRIM_W-1:0] prim
);

  always_comb begin
    prim = '0;
    unique case (st)
      ST_IDLE: begin
        prim[FN_LO +: FN_W] = FN_NULL;
      end
      ST_XFER: begin
        prim[FN_LO +: FN_W] = FN_NULL;
        prim[CA_BIT]        = 1'b1;
      end
      ST_WAIT: begin
        prim[FN_LO +: FN_W] = FN_NULL;
        prim[CA_BIT]        = 1'b1;
        prim[IA_BIT]        = 1'b1;
      end
      ST_EXC: begin
        prim[FN_LO +: FN_W]  = FN_TAKE_EXC;
        prim[CODE_W-1:0]     = code;
      end
      default: prim = '0;
    endcase
  end

endmodule

// File: rtl/cp_resp_seq.sv
module cp_resp_seq
  import cp_resp_pkg::*;
#(
  parameter int unsigned CMD_W  = 16,
  parameter int unsigned PRIM_W = 16,
  parameter int unsigned CA_BIT = 13,
  parameter int unsigned IA_BIT = 8,
  parameter int unsigned FN_LO  = 9,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_data,
  input  logic              rsp_rd,
  output logic [PRIM_W-1:0] rsp_data,
  output logic              opnd_go,
  input  logic              opnd_done,
  output logic              exe_start,
  output logic [CMD_W-1:0]  exe_cmd,
  input  logic              exe_done,
  input  logic              exe_exc,
  input  logic [CODE_W-1:0] exe_code
);

  localparam logic [PRIM_W-1:0] PRIM_RELEASE =
    PRIM_W'(FN_NULL) << FN_LO;

  seq_st_e           st_nx;
  logic [CODE_W-1:0] code_nx;
  logic              consume;
  logic              launch;
  logic              busy;
  logic              exc_pend;
  logic [CODE_W-1:0] exc_code;
  logic [PRIM_W-1:0] prim_nx;

  cp_resp_busy #(.CODE_W(CODE_W)) u_busy (
    .clk      (clk),
    .rst      (rst),
    .launch   (launch),
    .exe_done (exe_done),
    .exe_exc  (exe_exc),
    .exe_code (exe_code),
    .consume  (consume),
    .busy     (busy),
    .exc_pend (exc_pend),
    .exc_code (exc_code)
  );

  cp_resp_ctl #(.CMD_W(CMD_W), .CODE_W(CODE_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .opnd_done (opnd_done),
    .busy      (busy),
    .exc_pend  (exc_pend),
    .exc_code  (exc_code),
    .st_nx     (st_nx),
    .code_nx   (code_nx),
    .consume   (consume),
    .launch    (launch),
    .opnd_go   (opnd_go),
    .exe_start (exe_start),
    .exe_cmd   (exe_cmd)
  );

  // Encoding the next state gives write-before-read ordering in one cycle
  cp_resp_enc #(
    .PRIM_W (PRIM_W),
    .CA_BIT (CA_BIT),
    .IA_BIT (IA_BIT),
    .FN_LO  (FN_LO),
    .CODE_W (CODE_W)
  ) u_enc (
    .st   (st_nx),
    .code (code_nx),
    .prim (prim_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_data <= PRIM_RELEASE;
    end else if (rsp_rd) begin
      rsp_data <= prim_nx;
    end
  end

  // R10: the response register moves only after a read
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rsp_rd) |-> $stable(rsp_data));

  // R4: no operand transfer starts while the unit is busy
  p_no_go_busy_r4: assert property (@(posedge clk) disable iff (rst)
    opnd_go |-> !busy);

  // R3: a hand-off to the unit always marks it busy
  p_busy_on_start_r3: assert property (@(posedge clk) disable iff (rst)
    exe_start |-> busy);

endmodule

// File: tb/cp_resp_seq_bench.sv
module cp_resp_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [15:0] cmd_data = '0;
  logic        rsp_rd = 1'b0;
  logic [15:0] rsp_data;
  logic        opnd_go;
  logic        opnd_done = 1'b0;
  logic        exe_start;
  logic [15:0] exe_cmd;
  logic        exe_done = 1'b0;
  logic        exe_exc = 1'b0;
  logic [3:0]  exe_code = '0;

  int checks = 0;
  int errors = 0;
  int go_cnt = 0;
  int start_cnt = 0;
  int cyc = 0;
  logic [15:0] last_cmd = '0;

  always #2 clk = ~clk;  // 250 MHz

  cp_resp_seq u_cp_resp_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .rsp_rd    (rsp_rd),
    .rsp_data  (rsp_data),
    .opnd_go   (opnd_go),
    .opnd_done (opnd_done),
    .exe_start (exe_start),
    .exe_cmd   (exe_cmd),
    .exe_done  (exe_done),
    .exe_exc   (exe_exc),
    .exe_code  (exe_code)
  );

  // Expected primitives from the requirement encodings
  function automatic int nullp(input int ca, input int ia);
    return (ca << 13) | (4 << 9) | (ia << 8);
  endfunction
  function automatic int excp(input int code);
    return (14 << 9) | code;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (opnd_go) go_cnt++;
      if (exe_start) begin
        start_cnt++;
        last_cmd = exe_cmd;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic do_write(input logic [15:0] w);
    cmd_wr = 1'b1; cmd_data = w;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask
  task automatic do_read(output int r);
    rsp_rd = 1'b1;
    @(negedge clk);
    rsp_rd = 1'b0;
    r = int'(rsp_data);
  endtask
  task automatic do_wr_rd(input logic [15:0] w, output int r);
    cmd_wr = 1'b1; cmd_data = w; rsp_rd = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0; rsp_rd = 1'b0;
    r = int'(rsp_data);
  endtask
  task automatic xfer_end();
    opnd_done = 1'b1;
    @(negedge clk);
    opnd_done = 1'b0;
  endtask
  task automatic unit_done(input logic exc, input logic [3:0] code);
    exe_done = 1'b1; exe_exc = exc; exe_code = code;
    @(negedge clk);
    exe_done = 1'b0; exe_exc = 1'b0; exe_code = '0;
  endtask

  initial begin
    int r;
    int g0;
    int s0;
    logic [15:0] w;
    idle(3);
    chk("R1 reset rsp", int'(rsp_data), nullp(0, 0));
    chk("R1 reset go", int'(opnd_go), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rsp after reset", int'(rsp_data), nullp(0, 0));
    chk("R1 start after reset", int'(exe_start), 0);

    for (int i = 0; i < 4; i++) begin
      w  = 16'h0A05 + 16'(i * 16'h0111);
      g0 = go_cnt;
      s0 = start_cnt;
      do_write(w); idle(1);
      chk("R2 one go pulse", go_cnt, g0 + 1);
      do_read(r);
      chk("R2 transfer primitive", r, nullp(1, 0));
      do_write(~w); idle(1);
      chk("R11 write in transfer no go", go_cnt, g0 + 1);
      do_read(r);
      chk("R11 write in transfer rsp", r, nullp(1, 0));
      xfer_end(); idle(1);
      chk("R3 start pulse", start_cnt, s0 + 1);
      chk("R3 R11 exe_cmd word", int'(last_cmd), int'(w));
      do_read(r);
      chk("R3 release primitive", r, nullp(0, 0));
      do_write(w ^ 16'h00F0); idle(4);
      chk("R4 no go while busy", go_cnt, g0 + 1);
      do_read(r);
      chk("R4 wait primitive", r, nullp(1, 1));
      do_write(16'hBEEF); idle(4);
      do_read(r);
      chk("R5 R11 wait primitive held", r, nullp(1, 1));
      unit_done(1'b0, 4'h0); idle(2);
      chk("R5 parked command starts", go_cnt, g0 + 2);
      do_read(r);
      chk("R5 parked in transfer", r, nullp(1, 0));
      xfer_end(); idle(2);
      chk("R10 rsp held without read", int'(rsp_data), nullp(1, 0));
      chk("R5 parked word to unit", int'(last_cmd), int'(w ^ 16'h00F0));
      unit_done(1'b0, 4'h0); idle(1);
    end

    for (int c = 0; c < 16; c++) begin
      w = 16'h2000 | 16'(c);
      do_write(w); xfer_end(); idle(1);
      g0 = go_cnt;
      do_write(w ^ 16'h0001); idle(1);
      unit_done(1'b1, 4'(c)); idle(3);
      do_read(r);
      chk("R6 take exception primitive", r, excp(c));
      chk("R6 parked not started", go_cnt, g0);
      do_write(w ^ 16'h0002); idle(1);
      do_read(r);
      chk("R8 restart after exception", r, nullp(1, 0));
      chk("R8 go after exception", go_cnt, g0 + 1);
      xfer_end(); unit_done(1'b0, 4'h0); idle(1);
    end

    do_write(16'h3333); xfer_end(); unit_done(1'b1, 4'h9); idle(1);
    g0 = go_cnt;
    do_write(16'h4444); idle(1);
    do_read(r);
    chk("R7 latched exception", r, excp(9));
    chk("R7 no go", go_cnt, g0);
    do_wr_rd(16'h5555, r);
    chk("R9 R8 write and read same cycle", r, nullp(1, 0));
    xfer_end(); idle(1);
    do_wr_rd(16'h6666, r);
    chk("R9 write and read while busy", r, nullp(1, 1));
    unit_done(1'b0, 4'h0); idle(2);
    do_read(r);
    chk("R5 parked after same-cycle write", r, nullp(1, 0));
    xfer_end(); idle(1);
    chk("R3 last word", int'(last_cmd), 16'h6666);
    unit_done(1'b0, 4'h0); idle(1);
    do_read(r);
    chk("R3 final release", r, nullp(0, 0));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule